// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags of a serial bus controller and turns them into one interrupt line and two DMA request lines. The bus engine and the data path around it report events as single-cycle set pulses, and the data path withdraws the ready flags through hardware clear pulses. Software sees five registers through a simple synchronous register port: an enable mask, a status register cleared by writing ones, a read-only vector register, a DMA enable register and a diagnostic control.

A revision input picks one of two register behaviours. With `rev_new` low (older behaviour), the vector register is live: reading it returns the lowest pending enabled event and acknowledges that event. In this mode, writes to the status register and the diagnostic register have no effect. With `rev_new` high (newer behaviour), the status register accepts clears, the diagnostic register can force the low flags set, and vector reads return zero. Read data and all three request outputs are registered.

Top module: `isv_unit`

## Requirements
- R1: `irq_o` is high exactly when (status[5:0] AND mask) is non-zero, one clock after the status or mask register takes that value.
- R2: With `rev_new` low, a read of the vector register (address 2) returns one plus the index of the lowest set bit of (status[5:0] AND mask). That single status bit is cleared and no other. The read returns 0 and clears nothing when no enabled bit is pending.
- R3: With `rev_new` high, a read of the vector register returns 0 and leaves the status register unchanged.
- R4: With `rev_new` high, a write to the status register (address 1) clears each status bit that is set in (write data AND 0x0027). Bits 3 (receive ready) and 4 (transmit ready) are cleared only by the `evt_clr` input. With `rev_new` low, status writes have no effect.
- R5: A write to the mask register (address 0) keeps bits 5:0 when `rev_new` is high and bits 4:0 when it is low. The other bits read back as zero.
- R6: A write to the DMA register (address 3) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Setting bit 15 clears mask bit 3, and setting bit 7 clears mask bit 4.
- R7: `dma_rx_req` equals status bit 3 while receive DMA is enabled and is low otherwise. `dma_tx_req` equals status bit 4 while transmit DMA is enabled and is low otherwise. Both follow one clock after the state changes.
- R8: With `rev_new` high, a write to the diagnostic register (address 4) with bit 11 set forces status bits 5:0 to one. With `rev_new` low, the write has no effect. The diagnostic register reads as 0.
- R9: Only status bits 0 to 5, 10, 11 and 15 hold state; set pulses on other bits are dropped. A status read returns those bits with bit 12 equal to `bus_busy` at the time of the read.
- R10: When a set pulse and a clear (from `evt_clr`, a status write or a vector read) hit the same status bit in the same cycle, the bit ends up set.
- R11: After reset, status, mask, DMA enables, read data and all three request outputs are zero. Read data appears on `reg_rdata` one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rev_new | input | 1 | 1 selects the newer register behaviour, 0 the older one |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 mask, 1 status, 2 vector, 3 DMA, 4 diagnostic |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one clock after the read strobe |
| bus_busy | input | 1 | Bus busy level, reported as status bit 12 |
| evt_set | input | 16 | Single-cycle set pulses for status bits |
| evt_clr | input | 16 | Single-cycle hardware clear pulses for status bits |
| irq_o | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
A wrong status or mask bit shows on `irq_o` or the DMA request lines one clock after the bad state forms, and on a status or mask read one clock after the read strobe. A vector read that picks the wrong bit, or clears more than one bit, shows in the returned value at once and in the following status read. The stimulus covers both revisions, both DMA directions, the set-against-clear collision and the dropping of bits that hold no state, so that each state bit can be traced to a port.

// File: rtl/isv_pkg.sv
package isv_pkg;

  // register addresses
  localparam logic [2:0] RA_MASK = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_VEC  = 3'd2;
  localparam logic [2:0] RA_DMA  = 3'd3;
  localparam logic [2:0] RA_DIAG = 3'd4;

  // status bit positions that other logic decodes
  localparam int ST_RRDY = 3;
  localparam int ST_XRDY = 4;
  localparam int ST_BUSY = 12;

  // status bits that hold state, and the bits software may clear
  localparam logic [15:0] STAT_IMPL = 16'h8C3F;
  localparam logic [15:0] STAT_SWCLR = 16'h0027;

  // DMA enable bits and the diagnostic force bit
  localparam int DMA_RX_BIT = 15;
  localparam int DMA_TX_BIT = 7;
  localparam int DIAG_FORCE_BIT = 11;
  localparam int FORCE_W = 6;

endpackage

// File: rtl/isv_rst_sync.sv
module isv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/isv_lsb_pick.sv
module isv_lsb_pick #(
  parameter int W = 6,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req_i,
  output logic [W-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);

  // below[i] is set when any request lower than i is present
  logic [W:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign below[i+1]  = below[i] | req_i[i];
    assign grant_o[i]  = req_i[i] & ~below[i];
  end

  assign found_o = below[W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/isv_status.sv
module isv_status #(
  parameter int          W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  // set wins over clear on the same bit
  always_comb begin
    stat_d  = ((stat_q & ~clr_i) | set_i) & IMPL;
    stat_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|(set_i & IMPL)) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_NO_STRAY_BIT: assert property (@(posedge clk) disable iff (!rst_n) (|(set_i & ~IMPL)) |=> ((stat_q & ~IMPL) == '0)); // R9

endmodule

// File: rtl/isv_out_stage.sv
module isv_out_stage #(
  parameter int MW     = 6,
  parameter int RX_BIT = 3,
  parameter int TX_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] stat_i,
  input  logic [MW-1:0] mask_i,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  output logic          irq_o,
  output logic          drq_rx_o,
  output logic          drq_tx_o
);

  logic irq_d, drq_rx_d, drq_tx_d;

  always_comb begin
    irq_d    = |(stat_i & mask_i);
    drq_rx_d = rx_en_i & stat_i[RX_BIT];
    drq_tx_d = tx_en_i & stat_i[TX_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      drq_rx_o <= 1'b0;
      drq_tx_o <= 1'b0;
    end else begin
      irq_o    <= irq_d;
      drq_rx_o <= drq_rx_d;
      drq_tx_o <= drq_tx_d;
    end
  end

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n) !rx_en_i |=> !drq_rx_o); // R7
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n) !tx_en_i |=> !drq_tx_o); // R7

endmodule

// File: rtl/isv_unit.sv
module isv_unit
  import isv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_new,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_busy,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [DATA_W-1:0] evt_clr,
  output logic              irq_o,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);

  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam logic [DATA_W-1:0] IMPL   = DATA_W'(STAT_IMPL);
  localparam logic [DATA_W-1:0] SWCLR  = DATA_W'(STAT_SWCLR);
  localparam logic [DATA_W-1:0] FORCEV = DATA_W'({FORCE_W{1'b1}});
  localparam logic [MASK_W-1:0] KEEP_NEW = {MASK_W{1'b1}};
  localparam logic [MASK_W-1:0] KEEP_OLD = {1'b0, {(MASK_W-1){1'b1}}};

  logic rst_s_n;

  isv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // address decode
  logic sel_mask, sel_stat, sel_vec, sel_dma, sel_diag;
  logic wr_mask, wr_stat, wr_dma, wr_diag, rd_vec;

  always_comb begin
    sel_mask = (reg_addr == ADDR_W'(RA_MASK));
    sel_stat = (reg_addr == ADDR_W'(RA_STAT));
    sel_vec  = (reg_addr == ADDR_W'(RA_VEC));
    sel_dma  = (reg_addr == ADDR_W'(RA_DMA));
    sel_diag = (reg_addr == ADDR_W'(RA_DIAG));
    wr_mask  = reg_wr & sel_mask;
    wr_stat  = reg_wr & sel_stat;
    wr_dma   = reg_wr & sel_dma;
    wr_diag  = reg_wr & sel_diag;
    rd_vec   = reg_rd & sel_vec;
  end

  // mask and DMA enable registers
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              mask_en;
  logic              rx_en_q, tx_en_q;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = reg_wdata[MASK_W-1:0] & (rev_new ? KEEP_NEW : KEEP_OLD);
    if (wr_dma) begin
      if (reg_wdata[DMA_RX_BIT]) mask_d[ST_RRDY] = 1'b0;
      if (reg_wdata[DMA_TX_BIT]) mask_d[ST_XRDY] = 1'b0;
    end
    mask_en = wr_mask | wr_dma;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else if (wr_dma) begin
      rx_en_q <= reg_wdata[DMA_RX_BIT];
      tx_en_q <= reg_wdata[DMA_TX_BIT];
    end
  end

  // vector selection over enabled pending bits
  logic [DATA_W-1:0] stat_q;
  logic [MASK_W-1:0] pending, grant;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_found;

  assign pending = stat_q[MASK_W-1:0] & mask_q;

  isv_lsb_pick #(.W(MASK_W)) u_pick (
    .req_i   (pending),
    .grant_o (grant),
    .idx_o   (pick_idx),
    .found_o (pick_found)
  );

  logic              vec_ack;
  logic [DATA_W-1:0] vec_val;

  always_comb begin
    vec_ack = rd_vec & ~rev_new & pick_found;
    vec_val = pick_found ? (DATA_W'(pick_idx) + DATA_W'(1)) : '0;
  end

  // status set and clear sources
  logic [DATA_W-1:0] set_all, clr_all;

  always_comb begin
    set_all = evt_set;
    if (wr_diag && rev_new && reg_wdata[DIAG_FORCE_BIT]) set_all = set_all | FORCEV;
    clr_all = evt_clr;
    if (wr_stat && rev_new) clr_all = clr_all | (reg_wdata & SWCLR);
    if (vec_ack)            clr_all = clr_all | DATA_W'(grant);
  end

  isv_status #(.W(DATA_W), .IMPL(IMPL)) u_stat (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .stat_o (stat_q)
  );

  isv_out_stage #(.MW(MASK_W), .RX_BIT(ST_RRDY), .TX_BIT(ST_XRDY)) u_out (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .stat_i   (stat_q[MASK_W-1:0]),
    .mask_i   (mask_q),
    .rx_en_i  (rx_en_q),
    .tx_en_i  (tx_en_q),
    .irq_o    (irq_o),
    .drq_rx_o (dma_rx_req),
    .drq_tx_o (dma_tx_req)
  );

  // read data path
  logic [DATA_W-1:0] rdata_d, stat_view, dma_view;

  always_comb begin
    stat_view          = stat_q;
    stat_view[ST_BUSY] = bus_busy;
    dma_view             = '0;
    dma_view[DMA_RX_BIT] = rx_en_q;
    dma_view[DMA_TX_BIT] = tx_en_q;
    rdata_d = '0;
    if (sel_mask) rdata_d = DATA_W'(mask_q);
    if (sel_stat) rdata_d = stat_view;
    if (sel_vec)  rdata_d = rev_new ? '0 : vec_val;
    if (sel_dma)  rdata_d = dma_view;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end

  AST_IRQ_UP: assert property (@(posedge clk) disable iff (!rst_s_n) (|(stat_q[MASK_W-1:0] & mask_q)) |=> irq_o); // R1
  AST_IRQ_DOWN: assert property (@(posedge clk) disable iff (!rst_s_n) !(|(stat_q[MASK_W-1:0] & mask_q)) |=> !irq_o); // R1
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n) (rd_vec && !rev_new && !reg_wr && evt_clr == '0) |=> ($countones($past(stat_q) & ~stat_q) <= 1)); // R2
  AST_VEC_NEW_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n) (rd_vec && rev_new) |=> (reg_rdata == '0)); // R3
  AST_MASK_OLD: assert property (@(posedge clk) disable iff (!rst_s_n) (wr_mask && !rev_new) |=> !mask_q[MASK_W-1]); // R5
  AST_DMA_RX_MASK: assert property (@(posedge clk) disable iff (!rst_s_n) (wr_dma && reg_wdata[DMA_RX_BIT]) |=> !mask_q[ST_RRDY]); // R6
  AST_DMA_TX_MASK: assert property (@(posedge clk) disable iff (!rst_s_n) (wr_dma && reg_wdata[DMA_TX_BIT]) |=> !mask_q[ST_XRDY]); // R6
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_s_n) (reg_rd && sel_stat) |=> (reg_rdata[ST_BUSY] == $past(bus_busy))); // R9

endmodule

// File: tb/isv_unit_test.sv
module isv_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rev_new;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        bus_busy;
  logic [15:0] evt_set, evt_clr;
  logic        irq_o, dma_rx_req, dma_tx_req;

  always #2 clk = ~clk; // 250 MHz

  isv_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rev_new    (rev_new),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .bus_busy   (bus_busy),
    .evt_set    (evt_set),
    .evt_clr    (evt_clr),
    .irq_o      (irq_o),
    .dma_rx_req (dma_rx_req),
    .dma_tx_req (dma_tx_req)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  // monitor: one read result is due at the negedge after each read strobe
  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected read result %h", "monitor", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        if (reg_rdata !== e.d) begin
          errors++;
          $display("FAIL %s read got %h expected %h", e.tag, reg_rdata, e.d);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, act, expv);
    end
  endtask

  task automatic drive(input logic wr, input logic [2:0] a, input logic [15:0] d,
                       input logic [15:0] s, input logic [15:0] c);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_set = s; evt_clr = c;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_set = '0; evt_clr = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(1'b1, a, d, '0, '0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] expv, input string tag);
    exp_t e;
    e.d = expv; e.tag = tag;
    exp_q.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rev_new = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; bus_busy = 1'b0; evt_set = '0; evt_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(irq_o, 1'b0, "R11 irq after reset");
    chk(dma_rx_req, 1'b0, "R11 rx request after reset");
    chk(dma_tx_req, 1'b0, "R11 tx request after reset");
    rd(3'd0, 16'h0000, "R11 mask after reset");
    rd(3'd1, 16'h0000, "R11 status after reset");
    rd(3'd3, 16'h0000, "R11 dma after reset");
    bus_busy = 1'b1;
    rd(3'd1, 16'h1000, "R9 busy reflected");
    bus_busy = 1'b0;

    // older behaviour
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h001F, "R5 mask width older");
    drive(1'b0, 3'd0, 16'h0, 16'h000A, 16'h0);
    settle();
    chk(irq_o, 1'b1, "R1 irq with pending bits");
    rd(3'd2, 16'h0002, "R2 vector lowest bit 1");
    rd(3'd2, 16'h0004, "R2 vector next bit 3");
    rd(3'd2, 16'h0000, "R2 vector empty");
    settle();
    chk(irq_o, 1'b0, "R1 irq after acknowledge");
    drive(1'b0, 3'd0, 16'h0, 16'h0002, 16'h0);
    wr(3'd1, 16'h0027);
    rd(3'd1, 16'h0002, "R4 status write ignored older");
    wr(3'd4, 16'h0800);
    rd(3'd1, 16'h0002, "R8 diag ignored older");

    // newer behaviour
    rev_new = 1'b1;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h003F, "R5 mask width newer");
    rd(3'd2, 16'h0000, "R3 vector zero newer");
    rd(3'd1, 16'h0002, "R3 status kept after vector read");
    wr(3'd4, 16'h0800);
    rd(3'd1, 16'h003F, "R8 diag forces low bits");
    settle();
    chk(irq_o, 1'b1, "R1 irq after force");
    wr(3'd1, 16'hFFFF);
    rd(3'd1, 16'h0018, "R4 write-one clear keeps ready flags");
    wr(3'd3, 16'h8080);
    rd(3'd3, 16'h8080, "R6 dma enables read back");
    rd(3'd0, 16'h0027, "R6 dma clears ready enables");
    chk(dma_rx_req, 1'b1, "R7 rx request follows ready");
    chk(dma_tx_req, 1'b1, "R7 tx request follows ready");
    chk(irq_o, 1'b0, "R1 irq with ready bits masked");
    drive(1'b0, 3'd0, 16'h0, 16'h0, 16'h0008);
    settle();
    chk(dma_rx_req, 1'b0, "R7 rx request drops with flag");
    chk(dma_tx_req, 1'b1, "R7 tx request stays");
    wr(3'd3, 16'h0000);
    settle();
    chk(dma_tx_req, 1'b0, "R7 tx request off when disabled");
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h8080, "R6 only enable bits kept");

    // collisions: set wins
    drive(1'b1, 3'd1, 16'h0001, 16'h0001, 16'h0);
    rd(3'd1, 16'h0011, "R10 set beats status write clear");
    drive(1'b0, 3'd0, 16'h0, 16'h0020, 16'h0020);
    rd(3'd1, 16'h0031, "R10 set beats hardware clear");

    // only bits that hold state
    drive(1'b0, 3'd0, 16'h0, 16'hFFFF, 16'h0);
    rd(3'd1, 16'h8C3F, "R9 only held bits stick");

    // older vector with narrow mask
    rev_new = 1'b0;
    wr(3'd0, 16'h0010);
    rd(3'd2, 16'h0005, "R2 vector respects mask");
    rd(3'd1, 16'h8C2F, "R2 only acknowledged bit cleared");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL monitor pending reads %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule